// File: doc/BRIEF.md
# Relocatable Instruction RAM Window

This block is a 4 KB on-chip memory with two clients. The memory holds 1024 words of 32 bits. An embedded script engine reads instructions and lookup-table words through a private fetch port. Each fetch returns one cycle after its request and never produces a host-side bus cycle. A host-side slave port reaches the same storage through a 4 KB window. The window's base address sits in a writable register and can be moved anywhere in the 32-bit address space.

Each host access that hits the window is accepted, held for a fixed number of target wait states and then completed with a one-cycle ready pulse. Writes are byte-granular through four lane enables. Reads always return the whole stored word. The two ports share one single-ported store. The fetch port has priority, so a host access that collides with a fetch is pushed back one cycle per colliding cycle. A strap input is sampled while reset is held. When the strap is asserted, the memory is switched off: host accesses no longer decode, and fetches come back flagged as errors.

Top module: `iram_window`

## Requirements
- R1: The store holds 1024 words of 32 bits. A host byte address selects word `h_addr[11:2]` inside the window, and the fetch port selects the word given by `f_addr` (0 to 1023).
- R2: While `rst_n` is low, the base register clears to zero and `h_ready` and `f_valid` are 0. The enable is captured as the inverse of `strap_dis` and does not change until the next reset.
- R3: A pulse on `base_wr` loads `base_wdata[31:12]` into the base register. `base_q[11:0]` always reads zero.
- R4: `h_hit` is 1 exactly when the memory is enabled and `h_addr[31:12]` equals `base_q[31:12]`.
- R5: A hitting host request first seen in cycle 0, with no fetch in cycle 2, gets `h_ready` high for exactly one cycle in cycle 3 (three wait states). On a read, `h_rdata` in that cycle carries the full stored word, whatever the value of `h_be`.
- R6: On a host write, each `h_be[i]` that is 1 writes bits `[8i+7:8i]` of `h_wdata`. Bytes whose enable is 0 keep their stored value.
- R7: A fetch requested in cycle N gives `f_valid`=1 in cycle N+1 with the addressed word on `f_data`, regardless of host activity.
- R8: A fetch wins the store over a host access in the same cycle. Every cycle with `f_req` high, from the cycle in which the host access would reach the store onward, delays `h_ready` by one cycle.
- R9: With the memory disabled, `h_hit` stays 0 and no host access completes. A fetch returns `f_valid`=1 with `f_err`=1 and `f_data`=0.
- R10: A host request that misses the window never gets `h_ready`, for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_dis | input | 1 | Disable strap, sampled during reset |
| base_wr | input | 1 | Load pulse for the window base register |
| base_wdata | input | 32 | New window base value |
| base_q | output | 32 | Current window base (low 12 bits zero) |
| f_req | input | 1 | Internal fetch request |
| f_addr | input | 10 | Fetch word index |
| f_valid | output | 1 | Fetch result valid |
| f_err | output | 1 | Fetch refused, memory disabled |
| f_data | output | 32 | Fetched word |
| h_req | input | 1 | Host request, held until ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 32 | Host byte address |
| h_be | input | 4 | Host byte-lane enables |
| h_wdata | input | 32 | Host write data |
| h_hit | output | 1 | Host address decodes into the window |
| h_ready | output | 1 | Host access complete |
| h_rdata | output | 32 | Host read data, valid with h_ready |

## Verification
The fetch and the host access can both want the single store in the same cycle. That is the cycle in which a waiting host access reaches its store slot. The bench provokes this by starting a host read and a burst of back-to-back fetches on the same clock edge, so the fetches span the host's slot and a few cycles after it. A behavioural model counts the blocked cycles, and each fetched word and the delayed ready cycle are compared against it on every clock. An explicit latency check confirms that the host completes on the first fetch-free cycle.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT,
    HS_DONE
  } host_state_e;

  // Window decode: upper address bits above the window size must agree.
  function automatic logic window_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base,
                                      input logic en,
                                      input int unsigned win_bits);
    return en && ((addr >> win_bits) == (base >> win_bits));
  endfunction

  // Clear the bits below the window size.
  function automatic logic [ADDR_W-1:0] align_base(input logic [ADDR_W-1:0] v,
                                                   input int unsigned win_bits);
    return (v >> win_bits) << win_bits;
  endfunction
endpackage

// File: rtl/iram_cfg.sv
module iram_cfg
  import iram_pkg::*;
#(
  parameter int unsigned WIN_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_dis,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic              en_q
);
  logic [ADDR_W-1:0] base_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_r <= '0;
      en_q   <= !strap_dis;
    end else if (base_wr) begin
      base_r <= align_base(base_wdata, WIN_BITS);
    end
  end

  assign base_q = base_r;

  // R2
  en_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(en_q));
endmodule

// File: rtl/iram_store.sv
module iram_store
  import iram_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [LANES-1:0] acc_be,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    rd_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (acc_en) begin
        if (acc_we && acc_be[g]) begin
          mem[acc_idx] <= acc_wdata[g*LANE_W +: LANE_W];
        end
        rd_q[g*LANE_W +: LANE_W] <= mem[acc_idx];
      end
    end
  end
endmodule

// File: rtl/iram_host_ctrl.sv
module iram_host_ctrl
  import iram_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned LANES = 4,
  parameter int unsigned HOST_WAIT = 3,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned DW = LANES * LANE_W,
  localparam int unsigned CNT_W = $clog2(HOST_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             hit,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    wdata,
  input  logic             fetch_busy,
  output logic             go,
  output logic             acc_we,
  output logic [IDX_W-1:0] acc_idx,
  output logic [LANES-1:0] acc_be,
  output logic [DW-1:0]    acc_wdata,
  output logic             ready
);
  localparam logic [CNT_W-1:0] SLOT = CNT_W'(HOST_WAIT - 1);

  host_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             host_accept;
  logic             at_slot;
  logic             host_stall;

  assign host_accept = (st_q == HS_IDLE) && req && hit;
  assign at_slot     = (st_q == HS_WAIT) && (cnt_q == SLOT);
  assign host_stall  = at_slot && fetch_busy;
  assign go          = at_slot && !fetch_busy;
  assign ready       = (st_q == HS_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= HS_IDLE;
      cnt_q     <= '0;
      acc_we    <= 1'b0;
      acc_idx   <= '0;
      acc_be    <= '0;
      acc_wdata <= '0;
    end else begin
      unique case (st_q)
        HS_IDLE: begin
          if (host_accept) begin
            st_q      <= HS_WAIT;
            cnt_q     <= CNT_W'(1);
            acc_we    <= we;
            acc_idx   <= idx;
            acc_be    <= be;
            acc_wdata <= wdata;
          end
        end
        HS_WAIT: begin
          if (go) begin
            st_q <= HS_DONE;
          end else if (!host_stall) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  // Cycle age of the current access, kept for the checks below.
  logic [7:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (host_accept) begin
      age_q <= 8'd1;
    end else if (st_q != HS_IDLE && age_q != 8'hFF) begin
      age_q <= age_q + 8'd1;
    end
  end

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  // R5
  ready_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (age_q >= 8'(HOST_WAIT)));
endmodule

// File: rtl/iram_window.sv
module iram_window
  import iram_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HOST_WAIT = 3,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned OFS_W = $clog2(LANES),
  localparam int unsigned WIN_BITS = IDX_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_dis,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_q,
  input  logic              f_req,
  input  logic [IDX_W-1:0]  f_addr,
  output logic              f_valid,
  output logic              f_err,
  output logic [DATA_W-1:0] f_data,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [LANES-1:0]  h_be,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_hit,
  output logic              h_ready,
  output logic [DATA_W-1:0] h_rdata
);
  logic              en_w;
  logic              host_go;
  logic              host_we;
  logic [IDX_W-1:0]  host_idx;
  logic [LANES-1:0]  host_be;
  logic [DATA_W-1:0] host_wdata;
  logic              st_en;
  logic              st_we;
  logic [IDX_W-1:0]  st_idx;
  logic [DATA_W-1:0] rd_q;
  logic              fv_q;
  logic              ferr_q;

  iram_cfg #(.WIN_BITS(WIN_BITS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_dis (strap_dis),
    .base_wr   (base_wr),
    .base_wdata(base_wdata),
    .base_q    (base_q),
    .en_q      (en_w)
  );

  assign h_hit = window_hit(h_addr, base_q, en_w, WIN_BITS);

  iram_host_ctrl #(
    .WORDS    (WORDS),
    .LANES    (LANES),
    .HOST_WAIT(HOST_WAIT)
  ) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (h_req),
    .hit       (h_hit),
    .we        (h_we),
    .idx       (h_addr[WIN_BITS-1:OFS_W]),
    .be        (h_be),
    .wdata     (h_wdata),
    .fetch_busy(f_req),
    .go        (host_go),
    .acc_we    (host_we),
    .acc_idx   (host_idx),
    .acc_be    (host_be),
    .acc_wdata (host_wdata),
    .ready     (h_ready)
  );

  // Fetch port owns the store whenever it asks.
  assign st_en  = f_req || host_go;
  assign st_we  = !f_req && host_go && host_we;
  assign st_idx = f_req ? f_addr : host_idx;

  iram_store #(.WORDS(WORDS), .LANES(LANES)) u_store (
    .clk      (clk),
    .acc_en   (st_en),
    .acc_we   (st_we),
    .acc_idx  (st_idx),
    .acc_be   (host_be),
    .acc_wdata(host_wdata),
    .rd_q     (rd_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q   <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      fv_q   <= f_req;
      ferr_q <= f_req && !en_w;
    end
  end

  assign f_valid = fv_q;
  assign f_err   = ferr_q;
  assign f_data  = (fv_q && !ferr_q) ? rd_q : '0;
  assign h_rdata = h_ready ? rd_q : '0;

  // R7
  fetch_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_req |=> f_valid);
  // R8
  fetch_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |-> !$past(f_req));
  // R9
  disabled_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_err |-> !en_w);
  // R9
  ready_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |-> en_w);
endmodule

// File: tb/iram_window_tb.sv
module iram_window_tb;
  localparam int HW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_dis = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [31:0] base_q;
  logic        f_req = 1'b0;
  logic [9:0]  f_addr = '0;
  logic        f_valid, f_err;
  logic [31:0] f_data;
  logic        h_req = 1'b0;
  logic        h_we = 1'b0;
  logic [31:0] h_addr = '0;
  logic [3:0]  h_be = '0;
  logic [31:0] h_wdata = '0;
  logic        h_hit, h_ready;
  logic [31:0] h_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  iram_window u_dut (
    .clk(clk), .rst_n(rst_n), .strap_dis(strap_dis),
    .base_wr(base_wr), .base_wdata(base_wdata), .base_q(base_q),
    .f_req(f_req), .f_addr(f_addr), .f_valid(f_valid), .f_err(f_err), .f_data(f_data),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
    .h_hit(h_hit), .h_ready(h_ready), .h_rdata(h_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mem [1024];
  bit          m_en, m_busy, m_ready, m_rd_chk, m_fv, m_ferr;
  logic [31:0] m_base, m_rdata, m_fdata, m_wd;
  int          m_elapsed, m_idx;
  bit          m_we;
  logic [3:0]  m_be;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = !strap_dis; m_base = '0; m_busy = 0; m_ready = 0;
      m_fv = 0; m_ferr = 0; m_rd_chk = 0;
    end else begin
      bit hit_now, nr;
      hit_now = m_en && (h_addr[31:12] == m_base[31:12]);
      nr = 0;
      m_fv = f_req;
      m_ferr = f_req && !m_en;
      m_fdata = (f_req && m_en) ? m_mem[f_addr] : 32'h0;
      if (m_ready) begin
        // completion cycle: nothing new accepted
      end else if (!m_busy) begin
        if (h_req && hit_now) begin
          m_busy = 1; m_elapsed = 1;
          m_we = h_we; m_idx = int'(h_addr[11:2]); m_be = h_be; m_wd = h_wdata;
        end
      end else if (m_elapsed >= HW - 1 && !f_req) begin
        m_rdata = m_mem[m_idx];
        m_rd_chk = !m_we;
        if (m_we) begin
          for (int b = 0; b < 4; b++)
            if (m_be[b]) m_mem[m_idx][8*b +: 8] = m_wd[8*b +: 8];
        end
        nr = 1; m_busy = 0;
      end else if (m_elapsed < HW - 1) begin
        m_elapsed++;
      end
      m_ready = nr;
      if (base_wr) m_base = {base_wdata[31:12], 12'h000};
    end
  end

  always begin
    @(posedge clk);
    #5;
    if (rst_n && !finished) begin
      chk(h_ready == m_ready, "R5/R8 h_ready vs model", 32'(h_ready), 32'(m_ready));
      if (m_ready && m_rd_chk)
        chk(h_rdata == m_rdata, "R5 h_rdata vs model", h_rdata, m_rdata);
      chk(f_valid == m_fv, "R7 f_valid vs model", 32'(f_valid), 32'(m_fv));
      chk(f_err == m_ferr, "R9 f_err vs model", 32'(f_err), 32'(m_ferr));
      if (m_fv) chk(f_data == m_fdata, "R7 f_data vs model", f_data, m_fdata);
      chk(h_hit == (m_en && h_addr[31:12] == m_base[31:12]), "R4 h_hit vs model",
          32'(h_hit), 32'(m_en && h_addr[31:12] == m_base[31:12]));
      chk(base_q == m_base, "R3 base_q vs model", base_q, m_base);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_reset(input bit dis);
    @(negedge clk);
    rst_n = 0; strap_dis = dis;
    repeat (3) @(negedge clk);
    rst_n = 1; strap_dis = 0;
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_wr = 1; base_wdata = v;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic host(input bit we, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    h_req = 1; h_we = we; h_addr = a; h_be = be; h_wdata = wd;
    lat = 0; rd = '0;
    forever begin
      @(posedge clk); #5;
      lat++;
      if (h_ready) begin rd = h_rdata; break; end
      if (lat > 40) break;
    end
    @(negedge clk); h_req = 0;
  endtask

  task automatic fetch_one(input logic [9:0] a, output logic [31:0] d, output bit v, output bit e);
    @(negedge clk); f_req = 1; f_addr = a;
    @(posedge clk); #5;
    d = f_data; v = f_valid; e = f_err;
    @(negedge clk); f_req = 0;
  endtask

  task automatic fetch_burst(input logic [9:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); f_req = 1; f_addr = a + 10'(i);
    end
    @(negedge clk); f_req = 0;
  endtask

  task automatic hold_miss(input logic [31:0] a, input int n, input string req);
    @(negedge clk); h_req = 1; h_we = 0; h_addr = a; h_be = 4'hF;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      chk(h_ready == 0, req, 32'(h_ready), 32'h0);
      chk(h_hit == 0, req, 32'(h_hit), 32'h0);
    end
    @(negedge clk); h_req = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] rd;
    int lat;
    logic [31:0] d;
    bit v, e;

    do_reset(0);
    #5;
    // R2 reset state
    chk(h_ready == 0, "R2 h_ready after reset", 32'(h_ready), 0);
    chk(f_valid == 0, "R2 f_valid after reset", 32'(f_valid), 0);
    chk(base_q == 0, "R2 base_q after reset", base_q, 0);

    // R3 base alignment
    set_base(32'h8765_4ABC);
    #1;
    chk(base_q == 32'h8765_4000, "R3 base_q aligned", base_q, 32'h8765_4000);

    // R4 decode at window edges
    @(negedge clk); h_addr = 32'h8765_4FFC; #1;
    chk(h_hit == 1, "R4 hit top of window", 32'(h_hit), 1);
    h_addr = 32'h8765_5000; #1;
    chk(h_hit == 0, "R4 miss above window", 32'(h_hit), 0);
    h_addr = 32'h8765_3FFC; #1;
    chk(h_hit == 0, "R4 miss below window", 32'(h_hit), 0);

    // fill words 0..7 and the last word
    for (int i = 0; i < 8; i++) begin
      host(1, 32'h8765_4000 + 32'(4 * i), 4'hF, 32'hC0DE_0000 + 32'(i), rd, lat);
      chk(lat == HW, "R5 write latency", 32'(lat), HW);
    end
    host(1, 32'h8765_4FFC, 4'hF, 32'h1122_3344, rd, lat);

    // R5 read latency and data, be ignored on reads
    host(0, 32'h8765_4FFC, 4'h0, 32'h0, rd, lat);
    chk(lat == HW, "R5 read latency", 32'(lat), HW);
    chk(rd == 32'h1122_3344, "R5 read full word with be=0", rd, 32'h1122_3344);

    // R1 fetch of first and last word
    fetch_one(10'd1023, d, v, e);
    chk(v && !e && d == 32'h1122_3344, "R1 fetch word 1023", d, 32'h1122_3344);
    fetch_one(10'd0, d, v, e);
    chk(v && !e && d == 32'hC0DE_0000, "R1 fetch word 0", d, 32'hC0DE_0000);
    fetch_one(10'd5, d, v, e);
    chk(v && d == 32'hC0DE_0005, "R7 fetch word 5", d, 32'hC0DE_0005);

    // R6 byte lanes 0 and 2
    host(1, 32'h8765_4FFC, 4'b0101, 32'hAABB_CCDD, rd, lat);
    host(0, 32'h8765_4FFC, 4'hF, 32'h0, rd, lat);
    chk(rd == 32'h11BB_33DD, "R6 lanes 0 and 2 written", rd, 32'h11BB_33DD);
    host(1, 32'h8765_4FFC, 4'b1000, 32'h99FF_FFFF, rd, lat);
    host(0, 32'h8765_4FFC, 4'hF, 32'h0, rd, lat);
    chk(rd == 32'h99BB_33DD, "R6 lane 3 only", rd, 32'h99BB_33DD);

    // R8 fetch collides with host slot: fetches in cycles 0..4
    fork
      host(0, 32'h8765_4008, 4'hF, 32'h0, rd, lat);
      fetch_burst(10'd0, 5);
    join
    chk(lat == 6, "R8 host delayed by fetches", 32'(lat), 6);
    chk(rd == 32'hC0DE_0002, "R8 delayed read data", rd, 32'hC0DE_0002);
    // single conflicting fetch exactly in the slot cycle
    fork
      host(0, 32'h8765_4010, 4'hF, 32'h0, rd, lat);
      begin @(negedge clk); @(negedge clk); fetch_burst(10'd7, 1); end
    join
    chk(lat == HW + 1, "R8 one-cycle stall", 32'(lat), HW + 1);

    // R10 miss held
    hold_miss(32'h0000_4000, 12, "R10 miss never ready");

    // R9 disabled by strap
    do_reset(1);
    @(negedge clk); h_addr = 32'h0000_0010; #1;
    chk(h_hit == 0, "R9 no hit when disabled", 32'(h_hit), 0);
    hold_miss(32'h0000_0010, 10, "R9 host never ready when disabled");
    fetch_one(10'd3, d, v, e);
    chk(v && e, "R9 fetch error flag", {30'h0, v, e}, 32'h3);
    chk(d == 0, "R9 fetch data zero", d, 0);

    // R2 strap released: enabled again, base back to zero
    do_reset(0);
    @(negedge clk); h_addr = 32'h0000_0010; #1;
    chk(h_hit == 1, "R2 enabled after reset without strap", 32'(h_hit), 1);
    fetch_one(10'd3, d, v, e);
    chk(v && !e && d == 32'hC0DE_0003, "R7 fetch after re-enable", d, 32'hC0DE_0003);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule